// File: doc/BRIEF.md
# DPSK Receiver Acquisition and Tracking Controller

This block sequences a DPSK receiver from first symbol timing to frame reception. After reset it waits in acquisition. The first symbol strobe moves it into a frame-delimiter search. During that search the demodulated phase is formed non-coherently: the previous symbol's phase is subtracted from the current one. When the carrier loop reports lock, the block switches to coherent demodulation and passes the corrected phase through unchanged. If lock is lost, it drops back to differential demodulation.

A running window of the last 16 phase errors produces two values. The first is a frequency estimate for the NCO, which is the windowed mean. The second is a quality figure, which is the windowed variance. The search is guarded by a programmable timer counted in symbols. If the timer runs out before the start-frame delimiter is seen, the controller pulses an acquisition reset and starts over. A timer value of zero turns the guard off. The loop filters lie outside this block.

Top module: `demod_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (acquisition), and freq_est_o, quality_o, demod_o and acq_rst_o are all 0.
- R2: In acquisition (mode 0) the mode holds until a cycle with sym_stb_i high. After that cycle mode_o is 1 (differential search).
- R3: In mode 1 with lock_i high, the next mode is 2 (coherent). In mode 2 with lock_i low, the next mode is 1. Neither change clears the symbol timer.
- R4: Symbol strobes are counted while in modes 1 and 2. The strobe that leaves mode 0 is not counted. When the timeout_i-th counted strobe arrives with sfd_found_i low, the next cycle shows mode_o 0 and acq_rst_o high for exactly one cycle.
- R5: When timeout_i is 0, the controller never times out and acq_rst_o stays low.
- R6: sfd_found_i high in mode 1 or 2 gives mode 3 (frame) on the next cycle, even on a strobe that would otherwise time out. Mode 3 holds while sfd_found_i is high. When sfd_found_i goes low, mode 3 returns to mode 0 without an acq_rst_o pulse.
- R7: freq_est_o is floor(sum of the last 16 strobed phase_err_i values / 16), in two's complement. The window holds zeros after reset.
- R8: quality_o is floor(sum of squares of the window / 16) minus freq_est_o squared, clamped at 0.
- R9: In modes 0 and 1, and in mode 3 while lock_i is low, a strobe loads demod_o with phase_i minus the previous strobe's phase_i, modulo 2^PW. The previous phase is 0 after reset.
- R10: In mode 2, and in mode 3 while lock_i is high, a strobe loads demod_o with phase_i.
- R11: freq_est_o, quality_o and demod_o change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_stb_i | input | 1 | One-cycle symbol strobe |
| phase_err_i | input | PW | Signed carrier phase error of the symbol |
| phase_i | input | PW | Symbol phase after NCO correction |
| lock_i | input | 1 | Carrier loop tracking flag |
| sfd_found_i | input | 1 | Frame delimiter seen; held high for the frame |
| timeout_i | input | TW | Search timeout in symbols, 0 disables |
| mode_o | output | 2 | 0 acquisition, 1 differential search, 2 coherent search, 3 frame |
| demod_o | output | PW | Demodulated phase of the last strobe |
| freq_est_o | output | PW | Signed windowed mean phase error |
| quality_o | output | 2*PW | Windowed phase error variance |
| acq_rst_o | output | 1 | One-cycle pulse on search timeout |

## Verification
The checker relies on two properties of the inputs. First, sym_stb_i is a single-cycle pulse. Second, timeout_i is static during a search, so a pulse on acq_rst_o can be traced to the timeout value of the previous cycle. The bench changes timeout_i only while in acquisition and drives every strobe for one cycle, with idle cycles between mode-changing level inputs. The mode and timing properties are checked only in cycles without a strobe where a strobe would alter the expected next mode.

// File: rtl/demod_ctrl_pkg.sv
package demod_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_DIFF = 2'd1,
    ST_COH  = 2'd2,
    ST_SFD  = 2'd3
  } dstate_e;
endpackage

// File: rtl/demod_ctrl_fsm.sv
module demod_ctrl_fsm
  import demod_ctrl_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_stb_i,
  input  logic          lock_i,
  input  logic          sfd_found_i,
  input  logic [TW-1:0] timeout_i,
  output dstate_e       state_o,
  output logic          acq_rst_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  dstate_e       state_q, state_d;
  logic [TW-1:0] cnt_q;
  logic          searching, expire;

  assign searching = (state_q == ST_DIFF) || (state_q == ST_COH);
  assign expire    = sym_stb_i && (timeout_i != '0) &&
                     (cnt_q == timeout_i - TW'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACQ:  if (sym_stb_i) state_d = ST_DIFF;
      ST_DIFF: begin
        if (sfd_found_i)  state_d = ST_SFD;
        else if (expire)  state_d = ST_ACQ;
        else if (lock_i)  state_d = ST_COH;
      end
      ST_COH: begin
        if (sfd_found_i)  state_d = ST_SFD;
        else if (expire)  state_d = ST_ACQ;
        else if (!lock_i) state_d = ST_DIFF;
      end
      ST_SFD:  if (!sfd_found_i) state_d = ST_ACQ;
      default: state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ACQ;
      cnt_q     <= '0;
      acq_rst_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      acq_rst_o <= searching && !sfd_found_i && expire;
      if (!searching)          cnt_q <= '0;
      else if (sym_stb_i) begin
        if (expire)            cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/demod_ctrl_avg.sv
module demod_ctrl_avg #(
  parameter int PW     = 8,
  parameter int WIN_LG = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_stb_i,
  input  logic signed [PW-1:0] phase_err_i,
  output logic signed [PW-1:0] freq_est_o,
  output logic [2*PW-1:0]      quality_o
);
  localparam int WIN = 1 << WIN_LG;
  localparam int SW  = PW + WIN_LG;
  localparam int QW  = 2 * PW + WIN_LG;

  logic signed [PW-1:0]   hist_q [WIN];
  logic signed [SW-1:0]   sum_q;
  logic [QW-1:0]          sq_q;
  logic signed [2*PW-1:0] sq_new, sq_old, mean_sq;
  logic signed [PW-1:0]   oldest, mean;
  logic [2*PW-1:0]        msq;

  assign oldest  = hist_q[WIN-1];
  assign sq_new  = (2*PW)'(phase_err_i) * (2*PW)'(phase_err_i);
  assign sq_old  = (2*PW)'(oldest) * (2*PW)'(oldest);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN; i++) hist_q[i] <= '0;
      sum_q <= '0;
      sq_q  <= '0;
    end else if (sym_stb_i) begin
      hist_q[0] <= phase_err_i;
      for (int i = 1; i < WIN; i++) hist_q[i] <= hist_q[i-1];
      sum_q <= sum_q + SW'(phase_err_i) - SW'(oldest);
      sq_q  <= sq_q + QW'($unsigned(sq_new)) - QW'($unsigned(sq_old));
    end
  end

  // slicing off the low bits is a floor divide by the window length
  assign mean    = sum_q[SW-1:WIN_LG];
  assign msq     = sq_q[QW-1:WIN_LG];
  assign mean_sq = (2*PW)'(mean) * (2*PW)'(mean);

  assign freq_est_o = mean;
  assign quality_o  = (msq < $unsigned(mean_sq)) ? '0 : msq - $unsigned(mean_sq);
endmodule

// File: rtl/demod_ctrl_dpsk.sv
module demod_ctrl_dpsk #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_stb_i,
  input  logic          coherent_i,
  input  logic [PW-1:0] phase_i,
  output logic [PW-1:0] demod_o
);
  logic [PW-1:0] phase_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_d <= '0;
      demod_o <= '0;
    end else if (sym_stb_i) begin
      phase_d <= phase_i;
      demod_o <= coherent_i ? phase_i : phase_i - phase_d;
    end
  end
endmodule

// File: rtl/demod_ctrl.sv
module demod_ctrl
  import demod_ctrl_pkg::*;
#(
  parameter int PW = 8,
  parameter int TW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_stb_i,
  input  logic signed [PW-1:0] phase_err_i,
  input  logic [PW-1:0]        phase_i,
  input  logic                 lock_i,
  input  logic                 sfd_found_i,
  input  logic [TW-1:0]        timeout_i,
  output logic [1:0]           mode_o,
  output logic [PW-1:0]        demod_o,
  output logic signed [PW-1:0] freq_est_o,
  output logic [2*PW-1:0]      quality_o,
  output logic                 acq_rst_o
);
  dstate_e state;
  logic    coherent;

  demod_ctrl_fsm #(.TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_stb_i   (sym_stb_i),
    .lock_i      (lock_i),
    .sfd_found_i (sfd_found_i),
    .timeout_i   (timeout_i),
    .state_o     (state),
    .acq_rst_o   (acq_rst_o)
  );

  assign coherent = (state == ST_COH) || ((state == ST_SFD) && lock_i);

  demod_ctrl_dpsk #(.PW(PW)) u_dpsk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sym_stb_i  (sym_stb_i),
    .coherent_i (coherent),
    .phase_i    (phase_i),
    .demod_o    (demod_o)
  );

  demod_ctrl_avg #(.PW(PW), .WIN_LG(4)) u_avg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_stb_i   (sym_stb_i),
    .phase_err_i (phase_err_i),
    .freq_est_o  (freq_est_o),
    .quality_o   (quality_o)
  );

  assign mode_o = state;
endmodule

// File: rtl/demod_ctrl_chk.sv
module demod_ctrl_chk #(
  parameter int PW = 8,
  parameter int TW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sym_stb_i,
  input logic                 lock_i,
  input logic                 sfd_found_i,
  input logic [TW-1:0]        timeout_i,
  input logic [1:0]           mode_o,
  input logic [PW-1:0]        demod_o,
  input logic [PW-1:0]        freq_est_o,
  input logic [2*PW-1:0]      quality_o,
  input logic                 acq_rst_o
);
  a_r2_acq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !sym_stb_i) |=> mode_o == 2'd0);

  a_r2_acq_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && sym_stb_i) |=> mode_o == 2'd1);

  a_r3_lock_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !lock_i && !sfd_found_i && !sym_stb_i) |=> mode_o == 2'd1);

  a_r3_lock_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && lock_i && !sfd_found_i && !sym_stb_i) |=> mode_o == 2'd2);

  a_r4_pulse_to_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_rst_o |-> (mode_o == 2'd0 && $past(sym_stb_i)));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_rst_o |=> !acq_rst_o);

  a_r5_no_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i == '0) |=> !acq_rst_o);

  a_r6_sfd_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd1 || mode_o == 2'd2) && sfd_found_i) |=> (mode_o == 2'd3 && !acq_rst_o));

  a_r6_sfd_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !sfd_found_i) |=> mode_o == 2'd0);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> ($stable(freq_est_o) && $stable(quality_o) && $stable(demod_o)));
endmodule

bind demod_ctrl demod_ctrl_chk #(.PW(PW), .TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_stb_i   (sym_stb_i),
  .lock_i      (lock_i),
  .sfd_found_i (sfd_found_i),
  .timeout_i   (timeout_i),
  .mode_o      (mode_o),
  .demod_o     (demod_o),
  .freq_est_o  (freq_est_o),
  .quality_o   (quality_o),
  .acq_rst_o   (acq_rst_o)
);

// File: tb/demod_ctrl_bench.sv
`timescale 1ns/1ps
module demod_ctrl_bench;
  localparam int PW = 8;
  localparam int TW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sym_stb = 1'b0;
  logic signed [PW-1:0] phase_err = '0;
  logic [PW-1:0]        phase = '0;
  logic                 lock = 1'b0;
  logic                 sfd = 1'b0;
  logic [TW-1:0]        tmo = '0;
  logic [1:0]           mode;
  logic [PW-1:0]        demod;
  logic signed [PW-1:0] freq;
  logic [2*PW-1:0]      qual;
  logic                 acq_rst;

  int n_chk = 0;
  int n_fail = 0;
  int hist [16];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  demod_ctrl #(.PW(PW), .TW(TW)) u_demod_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sym_stb_i   (sym_stb),
    .phase_err_i (phase_err),
    .phase_i     (phase),
    .lock_i      (lock),
    .sfd_found_i (sfd),
    .timeout_i   (tmo),
    .mode_o      (mode),
    .demod_o     (demod),
    .freq_est_o  (freq),
    .quality_o   (qual),
    .acq_rst_o   (acq_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    sym_stb = 0; lock = 0; sfd = 0; tmo = '0; phase = '0; phase_err = '0;
    for (int i = 0; i < 16; i++) hist[i] = 0;
    @(posedge clk); #1;
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic strobe(input int pe, input int ph);
    phase_err = PW'(pe);
    phase     = PW'(ph);
    sym_stb   = 1;
    @(posedge clk); #1;
    sym_stb   = 0;
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = pe;
  endtask

  task automatic check_stats(input string tag);
    int s, q, m, v;
    s = 0; q = 0;
    for (int i = 0; i < 16; i++) begin
      s += hist[i];
      q += hist[i] * hist[i];
    end
    m = s >>> 4;
    v = (q >>> 4) - m * m;
    if (v < 0) v = 0;
    chk({"R7 ", tag}, int'(freq), m);
    chk({"R8 ", tag}, int'(qual), v);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mode", int'(mode), 0);
    chk("R1 freq", int'(freq), 0);
    chk("R1 quality", int'(qual), 0);
    chk("R1 demod", int'(demod), 0);
    chk("R1 acq_rst", int'(acq_rst), 0);
    idle(3);
    chk("R2 acq holds without strobe", int'(mode), 0);
    strobe(0, 0);
    chk("R2 strobe enters search", int'(mode), 1);
  endtask

  task automatic t_timeout();
    do_reset();
    tmo = 5;
    strobe(0, 0);
    chk("R4 search entered", int'(mode), 1);
    repeat (4) strobe(0, 0);
    chk("R4 before limit mode", int'(mode), 1);
    chk("R4 before limit pulse", int'(acq_rst), 0);
    strobe(0, 0);
    chk("R4 timeout mode", int'(mode), 0);
    chk("R4 timeout pulse", int'(acq_rst), 1);
    idle(1);
    chk("R4 pulse one cycle", int'(acq_rst), 0);
  endtask

  task automatic t_lock();
    do_reset();
    tmo = 10;
    strobe(0, 0);
    lock = 1; idle(1);
    chk("R3 lock to coherent", int'(mode), 2);
    repeat (3) strobe(0, 0);
    lock = 0; idle(1);
    chk("R3 loss to differential", int'(mode), 1);
    lock = 1; idle(1);
    chk("R3 relock", int'(mode), 2);
    repeat (6) strobe(0, 0);
    chk("R3 timer kept, no early timeout", int'(mode), 2);
    strobe(0, 0);
    chk("R3 R4 timeout after ten counted", int'(mode), 0);
    chk("R4 pulse after lock changes", int'(acq_rst), 1);
    lock = 0;
  endtask

  task automatic t_sfd();
    do_reset();
    tmo = 3;
    strobe(0, 0);
    repeat (2) strobe(0, 0);
    sfd = 1;
    strobe(0, 0);
    chk("R6 sfd beats timeout mode", int'(mode), 3);
    chk("R6 sfd beats timeout pulse", int'(acq_rst), 0);
    repeat (5) strobe(0, 0);
    chk("R6 frame held", int'(mode), 3);
    sfd = 0; idle(1);
    chk("R6 frame end to acq", int'(mode), 0);
    chk("R6 frame end no pulse", int'(acq_rst), 0);
  endtask

  task automatic t_disable();
    int pulses;
    do_reset();
    tmo = 0;
    pulses = 0;
    strobe(0, 0);
    for (int i = 0; i < 300; i++) begin
      strobe(0, 0);
      if (acq_rst) pulses++;
    end
    chk("R5 mode stays in search", int'(mode), 1);
    chk("R5 no pulses", pulses, 0);
  endtask

  task automatic t_avg();
    do_reset();
    strobe(16, 0);
    check_stats("partial window");
    for (int i = 0; i < 16; i++) strobe(20, 0);
    check_stats("constant 20");
    chk("R8 constant zero variance", int'(qual), 0);
    for (int i = 0; i < 16; i++) strobe((i % 2 == 0) ? 10 : -10, 0);
    check_stats("alternating");
    chk("R8 alternating variance", int'(qual), 100);
    for (int i = 0; i < 16; i++) strobe(-3, 0);
    check_stats("constant -3");
    for (int i = 0; i < 16; i++) begin
      strobe(i * 9 - 70, 0);
      if (i % 4 == 3) check_stats("ramp");
    end
    strobe(-128, 0);
    check_stats("extreme");
    phase_err = 8'sd55;
    idle(4);
    check_stats("R11 no strobe no change");
  endtask

  task automatic t_demod();
    do_reset();
    strobe(0, 10);
    chk("R9 first diff", int'($signed(demod)), 10);
    strobe(0, 30);
    chk("R9 diff up", int'($signed(demod)), 20);
    strobe(0, 25);
    chk("R9 diff negative", int'($signed(demod)), -5);
    strobe(0, -100);
    strobe(0, 100);
    chk("R9 diff wraps", int'($signed(demod)), -56);
    lock = 1; idle(1);
    strobe(0, 100);
    chk("R10 coherent pass", int'($signed(demod)), 100);
    strobe(0, -50);
    chk("R10 coherent negative", int'($signed(demod)), -50);
    phase = 8'd77;
    idle(3);
    chk("R11 demod holds", int'($signed(demod)), -50);
    lock = 0; idle(1);
    strobe(0, 60);
    chk("R9 back to diff", int'($signed(demod)), 110);
    lock = 1; idle(1);
    sfd = 1; idle(1);
    chk("R6 frame from coherent", int'(mode), 3);
    strobe(0, 7);
    chk("R10 frame locked coherent", int'($signed(demod)), 7);
    lock = 0;
    strobe(0, 9);
    chk("R9 frame unlocked diff", int'($signed(demod)), 2);
    sfd = 0; idle(1);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_lock();
    t_sfd();
    t_disable();
    t_avg();
    t_demod();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule